// File: doc/BRIEF.md
# Row-Locality DRAM Read Scheduler

This block sits between a queue of read requests and the command port of a multi-bank DRAM. Each request names a bank, a row and a tag. The block records which row is open in each bank. It puts one command on its command port per slot: idle, precharge, activate or read. It returns the tag of each completed read on the same slot as that read. Because of this, the requester can match out-of-order responses by tag alone.

The block gives priority to requests that hit the row already open in their bank. This reduces the dead slots spent on precharge and activate. It holds up to eight pending requests. In each free slot it picks the oldest pending request that hits an open row. If none hits, it picks the oldest pending request. A bypass counter on the oldest request stops it from waiting forever. A mode pin switches the block to strict arrival order, so that the two policies can be compared on the same traffic.

Top module: `rowlocal_sched`

## Requirements
- R1: A selected request whose bank is open on its row produces a single read command (cmdKind 3) with no precharge or activate for it.
- R2: A selected request whose bank is closed or open on another row produces a precharge (cmdKind 1), then PENALTY-2 idle slots (cmdKind 0), then an activate (cmdKind 2) of the request's bank and row, then the read in the next slot. All banks are closed after reset.
- R3: In locality mode (fcfsMode low), the oldest pending request that hits an open row issues before older requests that miss. For the arrival order bank0/row10, bank0/row11, bank0/row10, bank1/row12, bank1/row12, the reads come back in the order 1st, 3rd, 2nd, 4th, 5th, using 3 precharges.
- R4: When no pending request hits an open row, the oldest pending request is selected. Requests to distinct rows of a single bank are read in arrival order.
- R5: Once the oldest pending request has been bypassed AGE_CAP (16) times while it was the oldest, it is selected next, whether or not younger requests hit an open row.
- R6: Each bank keeps its own open row. Alternating hits to two banks that are already open cause no precharge.
- R7: rspValid is high exactly on the slots that carry a read command. rspTag, cmdBank and cmdRow on that slot are the tag, bank and row of the request being served.
- R8: With fcfsMode high, reads are served in strict arrival order. The R3 sequence then needs 4 precharges.
- R9: The request buffer holds DEPTH (8) entries. reqReady is low only while all of them are occupied.
- R10: During and right after reset, cmdKind is 0, rspValid is low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fcfsMode | input | 1 | 1 selects strict arrival order, 0 selects row-locality ordering |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Buffer can take a request |
| reqBank | input | BANK_W | Bank of the request |
| reqRow | input | ROW_W | Row of the request |
| reqTag | input | TAG_W | Tag returned with the read |
| cmdKind | output | 2 | 0 idle, 1 precharge, 2 activate, 3 read |
| cmdBank | output | BANK_W | Bank addressed by the command |
| cmdRow | output | ROW_W | Row addressed by the command |
| rspValid | output | 1 | A read completes on this slot |
| rspTag | output | TAG_W | Tag of the completed read |

## Verification
The hardest case to reach is the age cap. It only triggers when the buffer keeps an older miss at its head while at least one younger hit is present on every free slot, sixteen slots in a row. When requests arrive one per slot, a lone miss would be served at once. The stimulus therefore first opens bank 0 on one row. It then sends a miss to another bank, so the three-slot row switch lets the queue fill. Next come a miss to bank 0 and a long stream of bank 0 hits, which keep the head bypassed until it is forced out. The arrival order 1,2,3,4,5 is also replayed under both modes, and the precharges seen on the command port are counted.

// File: rtl/rowsched_pkg.sv
package rowsched_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_READ = 2'd3
  } cmd_e;

  // strobes from control to datapath for one command slot
  typedef struct packed {
    logic popEntry;  // remove the selected buffer entry
    logic loadCur;   // capture the selected entry as the row-switch target
    logic fromCur;   // command fields come from the captured target
    cmd_e cmd;       // command to place on the port next slot
  } strobe_t;

endpackage

// File: rtl/rowsched_dp.sv
module rowsched_dp
  import rowsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 6,
  parameter int DEPTH     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TAG_W-1:0]  reqTag,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  popIdx,
  output logic [DEPTH-1:0]  entValid,
  output logic [DEPTH-1:0]  entHit,
  output logic [1:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // age-ordered buffer: index 0 is the oldest entry
  logic [DEPTH-1:0]  vld, nVld;
  logic [BANK_W-1:0] entBank [DEPTH];
  logic [ROW_W-1:0]  entRow  [DEPTH];
  logic [TAG_W-1:0]  entTag  [DEPTH];
  logic [BANK_W-1:0] nBank   [DEPTH];
  logic [ROW_W-1:0]  nRow    [DEPTH];
  logic [TAG_W-1:0]  nTag    [DEPTH];
  logic [CNT_W-1:0]  fill, fillN, tail;
  logic              accept;

  // per-bank open-row table
  logic [NUM_BANKS-1:0] openVld;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];

  // row-switch target
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [TAG_W-1:0]  curTag;

  logic [BANK_W-1:0] selBank;
  logic [ROW_W-1:0]  selRow;
  logic [TAG_W-1:0]  selTag;

  assign reqReady = (fill != CNT_W'(DEPTH));
  assign accept   = reqValid && reqReady;
  assign entValid = vld;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
      assign entHit[g] = vld[g] && openVld[entBank[g]] && (openRow[entBank[g]] == entRow[g]);
    end
  endgenerate

  assign selBank = strb.fromCur ? curBank : entBank[popIdx];
  assign selRow  = strb.fromCur ? curRow  : entRow[popIdx];
  assign selTag  = strb.fromCur ? curTag  : entTag[popIdx];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nVld[i]  = vld[i];
      nBank[i] = entBank[i];
      nRow[i]  = entRow[i];
      nTag[i]  = entTag[i];
    end
    if (strb.popEntry) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= popIdx) begin
          nVld[i]  = vld[i+1];
          nBank[i] = entBank[i+1];
          nRow[i]  = entRow[i+1];
          nTag[i]  = entTag[i+1];
        end
      end
      nVld[DEPTH-1] = 1'b0;
    end
    tail = fill - CNT_W'(strb.popEntry);
    if (accept) begin
      nVld[tail[IDX_W-1:0]]  = 1'b1;
      nBank[tail[IDX_W-1:0]] = reqBank;
      nRow[tail[IDX_W-1:0]]  = reqRow;
      nTag[tail[IDX_W-1:0]]  = reqTag;
    end
    fillN = fill + CNT_W'(accept) - CNT_W'(strb.popEntry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld  <= '0;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entBank[i] <= '0;
        entRow[i]  <= '0;
        entTag[i]  <= '0;
      end
    end else begin
      vld  <= nVld;
      fill <= fillN;
      for (int i = 0; i < DEPTH; i++) begin
        entBank[i] <= nBank[i];
        entRow[i]  <= nRow[i];
        entTag[i]  <= nTag[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openVld <= '0;
      for (int b = 0; b < NUM_BANKS; b++) openRow[b] <= '0;
      curBank <= '0;
      curRow  <= '0;
      curTag  <= '0;
    end else begin
      if (strb.cmd == CMD_PRE) openVld[selBank] <= 1'b0;
      if (strb.cmd == CMD_ACT) begin
        openVld[curBank] <= 1'b1;
        openRow[curBank] <= curRow;
      end
      if (strb.loadCur) begin
        curBank <= entBank[popIdx];
        curRow  <= entRow[popIdx];
        curTag  <= entTag[popIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdKind  <= 2'd0;
      cmdBank  <= '0;
      cmdRow   <= '0;
      rspValid <= 1'b0;
      rspTag   <= '0;
    end else begin
      cmdKind  <= strb.cmd;
      cmdBank  <= selBank;
      cmdRow   <= selRow;
      rspValid <= (strb.cmd == CMD_READ);
      rspTag   <= selTag;
    end
  end

endmodule

// File: rtl/rowsched_ctrl.sv
module rowsched_ctrl
  import rowsched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PENALTY = 2,
  parameter int AGE_CAP = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fcfsMode,
  input  logic [DEPTH-1:0] entValid,
  input  logic [DEPTH-1:0] entHit,
  output strobe_t          strb,
  output logic [IDX_W-1:0] popIdx
);

  localparam int SLOT_W = $clog2(PENALTY) + 1;
  localparam int AGE_W  = $clog2(AGE_CAP + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SWITCH, ST_READ} state_e;

  state_e            state, stateN;
  logic [SLOT_W-1:0] slot, slotN;
  logic [AGE_W-1:0]  bypassCnt, bypassN;
  logic [IDX_W-1:0]  hitIdx, pickIdx;
  logic              anyHit, forced, pickHit;

  // oldest entry that hits its bank's open row
  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entHit[i]) begin
        hitIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  assign forced  = (bypassCnt >= AGE_W'(AGE_CAP));
  assign pickIdx = (!fcfsMode && anyHit && !forced) ? hitIdx : '0;
  assign pickHit = entHit[pickIdx];
  assign popIdx  = pickIdx;

  always_comb begin
    strb.popEntry = 1'b0;
    strb.loadCur  = 1'b0;
    strb.fromCur  = 1'b0;
    strb.cmd      = CMD_IDLE;
    stateN        = state;
    slotN         = slot;
    bypassN       = bypassCnt;
    case (state)
      ST_IDLE: begin
        if (entValid[0]) begin
          strb.popEntry = 1'b1;
          if (pickHit) begin
            strb.cmd = CMD_READ;
            bypassN  = (pickIdx != '0) ? bypassCnt + AGE_W'(1) : '0;
          end else begin
            strb.loadCur = 1'b1;
            strb.cmd     = CMD_PRE;
            bypassN      = '0;
            stateN       = ST_SWITCH;
            slotN        = SLOT_W'(1);
          end
        end
      end
      ST_SWITCH: begin
        strb.fromCur = 1'b1;
        if (slot == SLOT_W'(PENALTY - 1)) begin
          strb.cmd = CMD_ACT;
          stateN   = ST_READ;
        end else begin
          slotN = slot + SLOT_W'(1);
        end
      end
      ST_READ: begin
        strb.fromCur = 1'b1;
        strb.cmd     = CMD_READ;
        stateN       = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slot      <= '0;
      bypassCnt <= '0;
    end else begin
      state     <= stateN;
      slot      <= slotN;
      bypassCnt <= bypassN;
    end
  end

endmodule

// File: rtl/rowlocal_sched.sv
module rowlocal_sched
  import rowsched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 6,
  parameter int DEPTH     = 8,
  parameter int PENALTY   = 2,
  parameter int AGE_CAP   = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fcfsMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [1:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag
);

  localparam int IDX_W = $clog2(DEPTH);

  strobe_t          strb;
  logic [IDX_W-1:0] popIdx;
  logic [DEPTH-1:0] entValid;
  logic [DEPTH-1:0] entHit;

  rowsched_ctrl #(
    .DEPTH  (DEPTH),
    .PENALTY(PENALTY),
    .AGE_CAP(AGE_CAP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fcfsMode(fcfsMode),
    .entValid(entValid),
    .entHit  (entHit),
    .strb    (strb),
    .popIdx  (popIdx)
  );

  rowsched_dp #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .TAG_W    (TAG_W),
    .DEPTH    (DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqBank (reqBank),
    .reqRow  (reqRow),
    .reqTag  (reqTag),
    .strb    (strb),
    .popIdx  (popIdx),
    .entValid(entValid),
    .entHit  (entHit),
    .cmdKind (cmdKind),
    .cmdBank (cmdBank),
    .cmdRow  (cmdRow),
    .rspValid(rspValid),
    .rspTag  (rspTag)
  );

endmodule

// File: rtl/rowlocal_sched_chk.sv
module rowlocal_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int TAG_W     = 6,
  parameter int PENALTY   = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cmdKind,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ROW_W-1:0]  cmdRow,
  input logic              rspValid,
  input logic [TAG_W-1:0]  rspTag
);

  localparam int SLOT_W = $clog2(PENALTY + 1) + 1;

  // open rows as seen on the command port
  logic [NUM_BANKS-1:0] shOpen;
  logic [ROW_W-1:0]     shRow [NUM_BANKS];
  logic [SLOT_W-1:0]    preAge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shOpen <= '0;
      for (int b = 0; b < NUM_BANKS; b++) shRow[b] <= '0;
      preAge <= '0;
    end else begin
      if (cmdKind == 2'd1) shOpen[cmdBank] <= 1'b0;
      if (cmdKind == 2'd2) begin
        shOpen[cmdBank] <= 1'b1;
        shRow[cmdBank]  <= cmdRow;
      end
      if (cmdKind == 2'd1) preAge <= SLOT_W'(1);
      else if (preAge != '0 && preAge < SLOT_W'(PENALTY)) preAge <= preAge + SLOT_W'(1);
      else preAge <= '0;
    end
  end

  // R1
  read_open_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 2'd3) |-> (shOpen[cmdBank] && shRow[cmdBank] == cmdRow));

  // R2
  act_after_penalty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preAge == SLOT_W'(PENALTY - 1)) |-> (cmdKind == 2'd2));

  // R2
  read_after_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 2'd2) |=> (cmdKind == 2'd3 && $stable(cmdBank) && $stable(cmdRow)));

  // R7
  rsp_with_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == (cmdKind == 2'd3));

  // R10
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cmdKind == 2'd0 && !rspValid));

endmodule

bind rowlocal_sched rowlocal_sched_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ROW_W    (ROW_W),
  .TAG_W    (TAG_W),
  .PENALTY  (PENALTY)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdKind (cmdKind),
  .cmdBank (cmdBank),
  .cmdRow  (cmdRow),
  .rspValid(rspValid),
  .rspTag  (rspTag)
);

// File: tb/test_rowlocal_sched.sv
module test_rowlocal_sched;

  localparam int NB = 4;
  localparam int RW = 8;
  localparam int TW = 6;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fcfsMode = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic [TW-1:0] reqTag = '0;
  logic [1:0]    cmdKind;
  logic [1:0]    cmdBank;
  logic [RW-1:0] cmdRow;
  logic          rspValid;
  logic [TW-1:0] rspTag;

  always #4 clk = ~clk;

  rowlocal_sched i_rowlocal_sched (
    .clk(clk), .rstN(rstN), .fcfsMode(fcfsMode),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqTag(reqTag),
    .cmdKind(cmdKind), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .rspValid(rspValid), .rspTag(rspTag)
  );

  typedef struct {
    int tag;
    int bank;
    int row;
    string req;
  } exp_t;

  exp_t expQ[$];
  int   testsRun = 0;
  int   testsFailed = 0;
  int   preCount = 0;
  int   accepted = 0;
  int   completed = 0;
  bit   sawFull = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expectRd(input int tag, input int bank, input int row, input string req);
    exp_t e;
    e.tag = tag; e.bank = bank; e.row = row; e.req = req;
    expQ.push_back(e);
  endtask

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic sendReq(input int bank, input int row, input int tag);
    reqValid = 1'b1;
    reqBank  = 2'(bank);
    reqRow   = RW'(row);
    reqTag   = TW'(tag);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset(input bit mode);
    rstN = 1'b0;
    fcfsMode = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) if (rstN && reqValid && reqReady) accepted++;

  // monitor: compares every completed read against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdKind == 2'd1) preCount++;
      if (rspValid) begin
        completed++;
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected read tag", int'(rspTag), -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(int'(rspTag) == e.tag, e.req, "read tag order", int'(rspTag), e.tag);
          check(int'(cmdBank) == e.bank && int'(cmdRow) == e.row, "R7",
                "read row for tag", int'(cmdRow), e.row);
        end
      end
      if (!reqReady && !sawFull) begin
        sawFull = 1'b1;
        // R9: ready drops only with a full buffer
        check(accepted - completed >= DP, "R9", "pending when not ready",
              accepted - completed, DP);
      end
    end
  end

  initial begin
    int p0;
    // R10: reset state
    repeat (2) @(negedge clk);
    check(cmdKind == 2'd0, "R10", "cmdKind in reset", int'(cmdKind), 0);
    check(rspValid == 1'b0, "R10", "rspValid in reset", int'(rspValid), 0);
    doReset(1'b0);
    check(reqReady == 1'b1, "R10", "reqReady after reset", int'(reqReady), 1);
    check(cmdKind == 2'd0 && !rspValid, "R10", "idle after reset", int'(cmdKind), 0);

    // R3: grouped order 1,3,2,4,5 with 3 row switches
    p0 = preCount;
    expectRd(1, 0, 10, "R3"); expectRd(3, 0, 10, "R3"); expectRd(2, 0, 11, "R3");
    expectRd(4, 1, 12, "R3"); expectRd(5, 1, 12, "R3");
    sendReq(0, 10, 1); sendReq(0, 11, 2); sendReq(0, 10, 3);
    sendReq(1, 12, 4); sendReq(1, 12, 5);
    waitDrain();
    check(preCount - p0 == 3, "R3", "precharges grouped", preCount - p0, 3);

    // R8: strict arrival order, 4 row switches
    doReset(1'b1);
    p0 = preCount;
    expectRd(1, 0, 10, "R8"); expectRd(2, 0, 11, "R8"); expectRd(3, 0, 10, "R8");
    expectRd(4, 1, 12, "R8"); expectRd(5, 1, 12, "R8");
    sendReq(0, 10, 1); sendReq(0, 11, 2); sendReq(0, 10, 3);
    sendReq(1, 12, 4); sendReq(1, 12, 5);
    waitDrain();
    check(preCount - p0 == 4, "R8", "precharges in arrival order", preCount - p0, 4);

    // R5: age cap forces the bypassed head after 16 younger hits
    doReset(1'b0);
    p0 = preCount;
    expectRd(0, 0, 10, "R2");
    sendReq(0, 10, 0);
    waitDrain();
    check(preCount - p0 == 1, "R2", "closed bank needs a switch", preCount - p0, 1);
    expectRd(1, 1, 13, "R2");
    for (int t = 3; t <= 18; t++) expectRd(t, 0, 10, "R1");
    expectRd(2, 0, 11, "R5");
    for (int t = 19; t <= 22; t++) expectRd(t, 0, 10, "R5");
    sendReq(1, 13, 1);
    sendReq(0, 11, 2);
    for (int t = 3; t <= 22; t++) sendReq(0, 10, t);
    waitDrain();
    check(preCount - p0 == 4, "R5", "precharges with age cap", preCount - p0, 4);

    // R6: two open banks, alternating hits, no precharge
    p0 = preCount;
    expectRd(30, 0, 10, "R6"); expectRd(31, 1, 13, "R6");
    expectRd(32, 0, 10, "R6"); expectRd(33, 1, 13, "R6");
    sendReq(0, 10, 30); sendReq(1, 13, 31); sendReq(0, 10, 32); sendReq(1, 13, 33);
    waitDrain();
    check(preCount - p0 == 0, "R6", "precharges on open banks", preCount - p0, 0);

    // R4 and R9: distinct rows of one bank, served oldest first, buffer fills
    p0 = preCount;
    for (int t = 0; t < 16; t++) expectRd(40 + t, 2, 30 + t, "R4");
    for (int t = 0; t < 16; t++) sendReq(2, 30 + t, 40 + t);
    waitDrain();
    check(preCount - p0 == 16, "R4", "precharges distinct rows", preCount - p0, 16);
    check(sawFull, "R9", "reqReady seen low", int'(sawFull), 1);
    check(reqReady == 1'b1, "R9", "reqReady after drain", int'(reqReady), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R10 watchdog: got %0d cycles expected completion before %0d", 20000, 20000);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule